// File: doc/BRIEF.md
# Converter Update Pacer with Staged Data Register

This block sets the rate at which new samples reach a digital-to-analog converter. A programmable down-counter runs on a peripheral tick enable, and each time it passes through zero it reloads itself and raises a request flag. A DMA controller watches the flag through a gated request output and answers it by writing the next sample. That write also clears the flag.

Software reaches three registers over a simple word bus: a control register, a 16-bit reload register and the converter data register. The control register holds the request flag, a staging enable, the counter enable and a converter/DMA enable. When staging and counting are both on, data writes go into a hidden stage register. The stage is copied to the converter output only at a timeout, so samples change on the counter's schedule and not on the bus's. The counter itself cannot be reached from the bus.

Top module: `dac_pacer`

## Requirements
- R1: After reset every register reads 0 at addresses 0 (data), 1 (control) and 2 (reload), and `dac_value`, `dac_enable` and `dma_req` are 0.
- R2: In the control register, bit 1 (staging), bit 2 (counter enable) and bit 3 (converter/DMA enable) are written and read back. Bit 0 reads the request flag and ignores bus writes. Bits 31:4 read 0.
- R3: The reload register stores bits 15:0 of a write and reads bits 31:16 as 0.
- R4: While the counter is enabled it steps once per cycle with `tick` high and holds in cycles with `tick` low. Each 0→1 write of the counter-enable bit loads the reload value. With reload value N a timeout occurs on every (N+1)-th tick, the first one included.
- R5: A reload value of 0 gives a timeout on every enabled tick.
- R6: A timeout sets the request flag. A write to the data register clears it. If both happen in the same cycle, the flag ends up set.
- R7: `dma_req` equals the request flag ANDed with control bit 3, and `dac_enable` follows control bit 3.
- R8: When staging is inactive (bit 1 or bit 2 clear), a data write drives `dac_value` from the next clock edge onward.
- R9: When bits 1 and 2 are both set, a data write leaves `dac_value` unchanged and goes to the stage register. The stage is copied to `dac_value` at the next timeout.
- R10: If a staged write and a timeout fall in the same cycle, `dac_value` takes the previous stage contents and the new write stays in the stage for the following timeout.
- R11: While the counter-enable bit is clear, the counter holds and no timeout occurs. Enabling it again restarts from the reload value and not from the held count.
- R12: A read of the data register returns the `dac_value` currently driven, zero-extended. Data bits above the converter width are dropped on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Peripheral tick enable for the counter |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 reload |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dac_value | output | 12 | Value currently driven to the converter |
| dac_enable | output | 1 | Converter enable |
| dma_req | output | 1 | Request to the DMA controller |

## Verification
The bench sweeps reload values 0 to 6 and counts ticks to the flag over two periods. A counter that is off by one, or that skips the reload after a timeout, sets the flag one tick early or late. Turning the enable off and back on checks that counting restarts from the reload value. A design that resumes from the held count times out too soon. It also hits the cycles where a data write coincides with a tick. A design that gives the clear priority over the set loses a request. A design that commits the incoming word instead of the older stage skips a sample. Staging is also checked with only one of its two enable bits set, and a design that stages in that case freezes the output.

// File: rtl/dac_pacer_pkg.sv
`timescale 1ns/1ps
package dac_pacer_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_DATA   = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_RELOAD = 2'd2;

    // Control bit positions, visible to software
    localparam int CTL_REQ   = 0;
    localparam int CTL_STAGE = 1;
    localparam int CTL_CNTEN = 2;
    localparam int CTL_DMAEN = 3;
    localparam int CTL_W     = 4;

    // Packed so that field order equals bit order in the register
    typedef struct packed {
        logic dma_en;
        logic cnt_en;
        logic stage;
        logic req;
    } ctl_t;
endpackage

// File: rtl/pacer_countdown.sv
`timescale 1ns/1ps
module pacer_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic             timeout
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        timeout = 1'b0;
        if (load) begin
            st_d.cnt = reload;
        end else if (en && tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload;
                timeout  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(st_q.cnt)); // R11
    AST_RELOAD_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !load) |=> (st_q.cnt == $past(reload))); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !load && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)); // R4
endmodule

// File: rtl/pacer_dataregs.sv
`timescale 1ns/1ps
module pacer_dataregs #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              staged,
    input  logic              commit,
    output logic [DATA_W-1:0] active
);
    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] active;
    } data_st_t;

    data_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (staged) begin
            // Commit uses the stage as it stood before this cycle's write
            if (commit) st_d.active = st_q.stage;
            if (wr)     st_d.stage  = wdata;
        end else if (wr) begin
            st_d.active = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (staged && !commit) |=> $stable(active)); // R9
    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!staged && wr) |=> (active == $past(wdata))); // R8
    AST_COMMIT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (staged && commit) |=> (active == $past(st_q.stage))); // R10
endmodule

// File: rtl/dac_pacer.sv
`timescale 1ns/1ps
module dac_pacer
    import dac_pacer_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic [DATA_W-1:0]   dac_value,
    output logic                dac_enable,
    output logic                dma_req
);
    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] reload;
    } top_st_t;

    top_st_t st_d, st_q;

    logic data_wr, ctl_wr, reload_wr;
    logic cnt_load, timeout, staged;
    logic unused_wdata_hi;

    assign data_wr   = bus_we && (bus_addr == REG_DATA);
    assign ctl_wr    = bus_we && (bus_addr == REG_CTRL);
    assign reload_wr = bus_we && (bus_addr == REG_RELOAD);
    assign cnt_load  = ctl_wr && bus_wdata[CTL_CNTEN] && !st_q.ctl.cnt_en;
    assign staged    = st_q.ctl.stage && st_q.ctl.cnt_en;
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CNT_W];

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ctl.stage  = bus_wdata[CTL_STAGE];
            st_d.ctl.cnt_en = bus_wdata[CTL_CNTEN];
            st_d.ctl.dma_en = bus_wdata[CTL_DMAEN];
        end
        if (reload_wr) st_d.reload  = bus_wdata[CNT_W-1:0];
        if (data_wr)   st_d.ctl.req = 1'b0;
        if (timeout)   st_d.ctl.req = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pacer_countdown #(.CNT_W(CNT_W)) i_countdown (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (st_q.ctl.cnt_en),
        .tick    (tick),
        .load    (cnt_load),
        .reload  (st_q.reload),
        .timeout (timeout)
    );

    pacer_dataregs #(.DATA_W(DATA_W)) i_dataregs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (data_wr),
        .wdata  (bus_wdata[DATA_W-1:0]),
        .staged (staged),
        .commit (timeout),
        .active (dac_value)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_DATA:   bus_rdata[DATA_W-1:0] = dac_value;
            REG_CTRL:   bus_rdata[CTL_W-1:0]  = st_q.ctl;
            REG_RELOAD: bus_rdata[CNT_W-1:0]  = st_q.reload;
            default:    bus_rdata = '0;
        endcase
    end

    assign dac_enable = st_q.ctl.dma_en;
    assign dma_req    = st_q.ctl.req && st_q.ctl.dma_en;

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> dac_enable); // R7
    AST_FLAG_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> st_q.ctl.req); // R6
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !timeout) |=> !st_q.ctl.req); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CTRL) |-> (bus_rdata[BUS_W-1:CTL_W] == '0)); // R2
endmodule

// File: tb/test_dac_pacer.sv
`timescale 1ns/1ps
module test_dac_pacer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [11:0] dac_value;
    logic        dac_enable;
    logic        dma_req;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dac_pacer i_dac_pacer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .dac_value(dac_value),
        .dac_enable(dac_enable), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit with_tick = 1'b0);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d; tick = with_tick;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic flag_is(input string tag, input logic exp);
        logic [31:0] v;
        rd(2'd1, v);
        chk(tag, {31'd0, v[0]}, {31'd0, exp});
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 data", v, 0);
        rd(2'd1, v); chk("R1 ctrl", v, 0);
        rd(2'd2, v); chk("R1 reload", v, 0);
        chk("R1 outputs", {29'd0, dac_value == 0, dac_enable, dma_req}, 32'h4);

        // R2 control readback, reserved bits and bit 0
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R2 ctrl all ones", v, 32'hE);
        chk("R7 dac_enable on", {31'd0, dac_enable}, 1);
        wr(2'd1, 32'h0);
        rd(2'd1, v); chk("R2 ctrl cleared", v, 0);

        // R3 reload width
        wr(2'd2, 32'hABCD_1234);
        rd(2'd2, v); chk("R3 reload", v, 32'h1234);

        // R8 / R12 direct writes
        wr(2'd0, 32'hFFFF_F5A5);
        chk("R8 direct", {20'd0, dac_value}, 32'h5A5);
        rd(2'd0, v); chk("R12 data read", v, 32'h5A5);
        wr(2'd1, 32'h2);
        wr(2'd0, 32'h123);
        chk("R8 stage bit without counter", {20'd0, dac_value}, 32'h123);

        // R4 / R5 period sweep
        for (int r = 0; r <= 6; r++) begin
            wr(2'd1, 32'h0);
            wr(2'd2, r);
            wr(2'd1, 32'hC);
            wr(2'd0, 32'h0);
            for (int p = 0; p < 2; p++) begin
                if (r > 0) begin
                    ticks(r);
                    flag_is(r == 0 ? "R5 before" : "R4 before timeout", 1'b0);
                    chk("R7 no req", {31'd0, dma_req}, 0);
                end
                ticks(1);
                flag_is(r == 0 ? "R5 every tick" : "R4 timeout", 1'b1);
                chk("R7 req", {31'd0, dma_req}, 1);
                if (p == 0) wr(2'd0, 32'h0);
            end
        end

        // R7 gating, R2 bit 0 write ignored
        wr(2'd1, 32'h4);
        chk("R7 gated off", {31'd0, dma_req}, 0);
        flag_is("R2 bit0 ignores write", 1'b1);
        chk("R7 dac_enable off", {31'd0, dac_enable}, 0);

        // R6 set and clear in the same cycle; R5 on reload 0
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h4);
        wr(2'd0, 32'h0, 1'b1);
        flag_is("R6 set wins", 1'b1);
        wr(2'd0, 32'h0);
        flag_is("R6 cleared", 1'b0);

        // R11 hold while disabled, restart from reload
        wr(2'd1, 32'h0);
        wr(2'd2, 32'd5);
        wr(2'd1, 32'h4);
        wr(2'd0, 32'h0);
        ticks(2);
        wr(2'd1, 32'h0);
        ticks(10);
        flag_is("R11 no timeout disabled", 1'b0);
        wr(2'd1, 32'h4);
        ticks(5);
        flag_is("R11 restart not early", 1'b0);
        ticks(1);
        flag_is("R11 restart from reload", 1'b1);

        // R9 staged commit
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h111);
        wr(2'd2, 32'd2);
        wr(2'd1, 32'h6);
        wr(2'd0, 32'h222);
        chk("R9 held", {20'd0, dac_value}, 32'h111);
        rd(2'd0, v); chk("R12 read active", v, 32'h111);
        ticks(2);
        chk("R9 held until timeout", {20'd0, dac_value}, 32'h111);
        ticks(1);
        chk("R9 commit", {20'd0, dac_value}, 32'h222);

        // R10 staged write coinciding with timeout
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h6);
        wr(2'd0, 32'h333);
        chk("R9 staged again", {20'd0, dac_value}, 32'h222);
        wr(2'd0, 32'h444, 1'b1);
        chk("R10 old stage commits", {20'd0, dac_value}, 32'h333);
        ticks(1);
        chk("R10 new stage later", {20'd0, dac_value}, 32'h444);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule